// File: doc/BRIEF.md
# Two-Fold Almost Montgomery Reduction Pipeline

This block reduces a double-width product X = a·b (8S bits, where N = 4S is the operand width) to an N-bit value congruent to X·2^(-S) modulo an odd modulus m. It does not run a word-by-word reduction. Instead it folds the high part of the product twice, multiplying by precomputed powers of two reduced mod m. It then runs one S-bit Montgomery step. Each of the three stages can overflow its target width by one bit. That bit is dropped, and a flag records it. The three flags select a correction constant that is added at the end. At most two conditional subtractions of m then bring the value below 2^N.

The result is only almost reduced: it is below 2^N but may be m or larger. This is the form a modular exponentiation loop can feed straight back into the next multiply. The multiplier that forms X and the precomputation of the constants lie outside the block. All constants arrive on input ports. They must stay stable while any operation is in flight. The datapath is a four-stage pipeline with a valid/ready handshake on both sides.

Top module: `tsf_amm_reducer`

## Requirements
- R1: For an odd modulus with 2^(N-1) < m < 2^N and correctly precomputed constants, every result r satisfies r·2^S ≡ X (mod m) and r < 2^N.
- R2: The first fold splits X at bit 6S and computes high·fold6_k + low, where fold6_k = 2^(6S) mod m. A result reaching 2^(6S) sets flag c1 and keeps only the low 6S bits.
- R3: The second fold splits the 6S-bit value at bit 5S and computes high·fold5_k + low, where fold5_k = 2^(5S) mod m. A result reaching 2^(5S) sets flag c2 and keeps the low 5S bits.
- R4: The Montgomery step forms q = (low S bits · mont_k) mod 2^S, where mont_k = −m^(-1) mod 2^S, and adds m·q. This makes the low S bits zero. A sum reaching 2^(5S) sets c3 and is truncated. The value is then shifted right by S.
- R5: The correction added is entry c1·4 + c2·2 + c3. Entry 0 is zero. Entry i (1..7) is taken from corr_tab bits [(i−1)·N +: N].
- R6: After the correction, m is subtracted if the value is ≥ 2^N, and the test and subtraction are then repeated once. The output is bit-exact to this sequence.
- R7: The output is not fully reduced. A pre-subtraction value in [m, 2^N) is delivered unchanged, for example X = (m+5)·2^S gives m+5.
- R8: Results leave in acceptance order. An output held with out_ready low keeps out_valid and out_res stable. An accepted input appears at the output four cycles later when out_ready stays high.
- R9: While rst_n is low, out_valid is low. After reset the block reports in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Product on in_prod is valid |
| in_ready | output | 1 | Block accepts a product this cycle |
| in_prod | input | 8S | Double-width product X |
| mod_m | input | N | Odd modulus m |
| mont_k | input | S | −m^(-1) mod 2^S |
| fold6_k | input | N | 2^(6S) mod m |
| fold5_k | input | N | 2^(5S) mod m |
| corr_tab | input | 7N | Correction entries 1..7, entry i at [(i−1)·N +: N] |
| out_valid | output | 1 | Result on out_res is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_res | output | N | Almost-reduced result |

## Verification
On every cycle, the assertions check the following: the low S bits of the Montgomery sum are zero whenever that stage holds data, a stalled output stays stable, an accepted product enters the first stage, the output valid stays low during reset, and any presented modulus is odd with its top bit set. The arithmetic itself can only be shown by the bench scenarios. These compare each result bit for bit against a model of the fold/step/correct sequence and check the congruence independently. They also cover products that force fold carries, the counterexample-style modulus near 2^(N−1), and a directed case whose result lies above m. Latency, ordering under random backpressure, and the stall hold are also shown by scenario.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   // carry flags recorded by the three reduction stages; the packed order
   // is the correction table index (c1 is the most significant bit)
   typedef struct packed {
      logic c1;
      logic c2;
      logic c3;
   } tsf_flags_t;

   localparam int unsigned TSF_TAB_ENTRIES = 8;
   localparam int unsigned TSF_STAGES      = 4;
endpackage

// File: rtl/tsf_pipe_stage.sv
module tsf_pipe_stage #(
   parameter int W          = 8,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);
   logic         v_q;
   logic [W-1:0] d_q;
   logic         load;

   assign up_ready = !v_q || dn_ready;
   assign load     = up_ready && up_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        v_q <= 1'b0;
      else if (up_ready) v_q <= up_valid;
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    d_q <= '0;
            else if (load) d_q <= up_data;
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            if (load) d_q <= up_data;
         end
      end
   endgenerate

   assign dn_valid = v_q;
   assign dn_data  = d_q;
endmodule

// File: rtl/tsf_fold.sv
module tsf_fold #(
   parameter int IN_W  = 128,
   parameter int SPLIT = 96,
   parameter int CW    = 64
) (
   input  logic [IN_W-1:0]  val,
   input  logic [CW-1:0]    cst,
   output logic [SPLIT-1:0] res,
   output logic             carry
);
   localparam int HW = IN_W - SPLIT;

   generate
      if (HW + CW != SPLIT) begin : g_bad_geom
         $error("tsf_fold: high part times constant must fill the split width");
      end
      if (SPLIT <= CW || SPLIT <= HW) begin : g_bad_split
         $error("tsf_fold: split width must exceed both factor widths");
      end
   endgenerate

   logic [HW-1:0]    hi;
   logic [SPLIT-1:0] lo;
   logic [SPLIT-1:0] prod;
   logic [SPLIT:0]   sum;

   assign hi    = val[IN_W-1:SPLIT];
   assign lo    = val[SPLIT-1:0];
   assign prod  = {{(SPLIT-HW){1'b0}}, hi} * {{(SPLIT-CW){1'b0}}, cst};
   assign sum   = {1'b0, prod} + {1'b0, lo};
   assign res   = sum[SPLIT-1:0];
   assign carry = sum[SPLIT];
endmodule

// File: rtl/tsf_mont_step.sv
module tsf_mont_step #(
   parameter int S = 16
) (
   input  logic [5*S-1:0] val,
   input  logic [4*S-1:0] modm,
   input  logic [S-1:0]   kinv,
   output logic [4*S-1:0] res,
   output logic           carry,
   output logic [S-1:0]   low_bits
);
   localparam int VW = 5 * S;

   logic [S-1:0]  q;
   logic [VW-1:0] mq;
   logic [VW:0]   sum;

   assign q        = val[S-1:0] * kinv;
   assign mq       = {{S{1'b0}}, modm} * {{(4*S){1'b0}}, q};
   assign sum      = {1'b0, val} + {1'b0, mq};
   assign carry    = sum[VW];
   assign res      = sum[VW-1:S];
   assign low_bits = sum[S-1:0];
endmodule

// File: rtl/tsf_fixup.sv
module tsf_fixup #(
   parameter int N = 64
) (
   input  logic [N-1:0]                      val,
   input  tsf_pkg::tsf_flags_t               flags,
   input  logic [(tsf_pkg::TSF_TAB_ENTRIES-1)*N-1:0] tab,
   input  logic [N-1:0]                      modm,
   output logic [N-1:0]                      res
);
   localparam int NE = tsf_pkg::TSF_TAB_ENTRIES;

   logic [N-1:0] ent [NE];
   logic [N-1:0] pick;
   logic [N:0]   t0;
   logic [N:0]   t1;

   assign ent[0] = '0;
   generate
      for (genvar i = 1; i < NE; i++) begin : g_ent
         assign ent[i] = tab[(i-1)*N +: N];
      end
   endgenerate

   assign pick = ent[flags];
   assign t0   = {1'b0, val} + {1'b0, pick};
   assign t1   = t0[N] ? (t0 - {1'b0, modm}) : t0;
   assign res  = t1[N] ? (t1[N-1:0] - modm) : t1[N-1:0];
endmodule

// File: rtl/tsf_amm_reducer.sv
module tsf_amm_reducer #(
   parameter int S          = 16,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [8*S-1:0]   in_prod,
   input  logic [4*S-1:0]   mod_m,
   input  logic [S-1:0]     mont_k,
   input  logic [4*S-1:0]   fold6_k,
   input  logic [4*S-1:0]   fold5_k,
   input  logic [28*S-1:0]  corr_tab,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [4*S-1:0]   out_res
);
   import tsf_pkg::*;

   localparam int N   = 4 * S;
   localparam int XW  = 8 * S;
   localparam int W1  = 6 * S;
   localparam int W2  = 5 * S;
   localparam int D1  = W1 + 1;
   localparam int D2  = W2 + 2;
   localparam int D3  = N + 3;

   generate
      if (S < 2) begin : g_bad_s
         $error("tsf_amm_reducer: S must be at least 2");
      end
   endgenerate

   // stage 1: first fold
   logic [W1-1:0] f1_res;
   logic          f1_c;
   logic          s1_v, s1_rdy;
   logic [D1-1:0] s1_d;

   tsf_fold #(.IN_W(XW), .SPLIT(W1), .CW(N)) u_fold6 (
      .val(in_prod), .cst(fold6_k), .res(f1_res), .carry(f1_c)
   );

   tsf_pipe_stage #(.W(D1), .RESET_DATA(RESET_DATA)) u_st1 (
      .clk(clk), .rst_n(rst_n),
      .up_valid(in_valid), .up_ready(in_ready), .up_data({f1_c, f1_res}),
      .dn_valid(s1_v), .dn_ready(s1_rdy), .dn_data(s1_d)
   );

   // stage 2: second fold
   logic [W2-1:0] f2_res;
   logic          f2_c;
   logic          s2_v, s2_rdy;
   logic [D2-1:0] s2_d;

   tsf_fold #(.IN_W(W1), .SPLIT(W2), .CW(N)) u_fold5 (
      .val(s1_d[W1-1:0]), .cst(fold5_k), .res(f2_res), .carry(f2_c)
   );

   tsf_pipe_stage #(.W(D2), .RESET_DATA(RESET_DATA)) u_st2 (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s1_v), .up_ready(s1_rdy), .up_data({s1_d[W1], f2_c, f2_res}),
      .dn_valid(s2_v), .dn_ready(s2_rdy), .dn_data(s2_d)
   );

   // stage 3: one S-bit Montgomery step
   logic [N-1:0]  mt_res;
   logic          mt_c;
   logic [S-1:0]  mont_low;
   logic          s3_v, s3_rdy;
   logic [D3-1:0] s3_d;

   tsf_mont_step #(.S(S)) u_mont (
      .val(s2_d[W2-1:0]), .modm(mod_m), .kinv(mont_k),
      .res(mt_res), .carry(mt_c), .low_bits(mont_low)
   );

   tsf_pipe_stage #(.W(D3), .RESET_DATA(RESET_DATA)) u_st3 (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s2_v), .up_ready(s2_rdy),
      .up_data({s2_d[W2+1], s2_d[W2], mt_c, mt_res}),
      .dn_valid(s3_v), .dn_ready(s3_rdy), .dn_data(s3_d)
   );

   // stage 4: correction and conditional subtractions
   tsf_flags_t   fl;
   logic [N-1:0] fx_res;

   assign fl.c1 = s3_d[N+2];
   assign fl.c2 = s3_d[N+1];
   assign fl.c3 = s3_d[N];

   tsf_fixup #(.N(N)) u_fix (
      .val(s3_d[N-1:0]), .flags(fl), .tab(corr_tab), .modm(mod_m), .res(fx_res)
   );

   tsf_pipe_stage #(.W(N), .RESET_DATA(RESET_DATA)) u_st4 (
      .clk(clk), .rst_n(rst_n),
      .up_valid(s3_v), .up_ready(s3_rdy), .up_data(fx_res),
      .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_res)
   );
endmodule

// File: rtl/tsf_amm_chk.sv
module tsf_amm_chk #(
   parameter int S = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic [4*S-1:0] mod_m,
   input logic           s1_v,
   input logic           s2_v,
   input logic [S-1:0]   mont_low,
   input logic           out_valid,
   input logic           out_ready,
   input logic [4*S-1:0] out_res
);
   localparam int N = 4 * S;

   // R4: the Montgomery sum always clears its low S bits
   p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s2_v |-> (mont_low == '0));

   // R8: a stalled result stays put
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

   // R8: an accepted product occupies the first stage next cycle
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> s1_v);

   // R9: no output during reset
   p_reset_r9: assert property (@(posedge clk)
      !rst_n |-> !out_valid);

   // R1: presented modulus is odd with its top bit set
   p_modulus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (mod_m[N-1] && mod_m[0]));
endmodule

bind tsf_amm_reducer tsf_amm_chk #(.S(S)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .mod_m(mod_m), .s1_v(s1_v), .s2_v(s2_v), .mont_low(mont_low),
   .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
);

// File: tb/tsf_amm_reducer_test.sv
module tsf_amm_reducer_test;
   localparam int S   = 16;
   localparam int N   = 4 * S;
   localparam int CLK = 10;
   typedef logic [255:0] big_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b1;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [8*S-1:0]  in_prod = '0;
   logic [N-1:0]    mod_m = '0;
   logic [S-1:0]    mont_k = '0;
   logic [N-1:0]    fold6_k = '0;
   logic [N-1:0]    fold5_k = '0;
   logic [7*N-1:0]  corr_tab = '0;
   logic            out_valid;
   logic            out_ready = 1'b0;
   logic [N-1:0]    out_res;

   always #(CLK/2) clk = ~clk;

   tsf_amm_reducer #(.S(S)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_prod(in_prod), .mod_m(mod_m), .mont_k(mont_k), .fold6_k(fold6_k),
      .fold5_k(fold5_k), .corr_tab(corr_tab), .out_valid(out_valid),
      .out_ready(out_ready), .out_res(out_res)
   );

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc   = 0;
   int   last_lat = 0;
   big_t last_out = '0;
   big_t gm, gk1, gc6, gc5;
   big_t gtab [8];
   logic [8*S-1:0] stim_q [$];
   big_t exp_q [$];
   big_t x_q [$];
   int   acc_q [$];
   bit   pend = 1'b0;

   task automatic chk(input bit ok, input string tag, input big_t act, input big_t exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic big_t pw(input int e);
      return big_t'(1) << e;
   endfunction

   // bit-exact sequence from R2..R6
   function automatic big_t model(input big_t x);
      big_t v, q;
      bit c1, c2, c3;
      v  = (x >> (6*S)) * gc6 + (x & (pw(6*S) - 1));
      c1 = (v >= pw(6*S)); v = v & (pw(6*S) - 1);
      v  = (v >> (5*S)) * gc5 + (v & (pw(5*S) - 1));
      c2 = (v >= pw(5*S)); v = v & (pw(5*S) - 1);
      q  = ((v & (pw(S) - 1)) * gk1) & (pw(S) - 1);
      v  = v + gm * q;
      c3 = (v >= pw(5*S)); v = v & (pw(5*S) - 1);
      v  = v >> S;
      v  = v + gtab[{c1, c2, c3}];
      if (v >= pw(N)) v = v - gm;
      if (v >= pw(N)) v = v - gm;
      return v;
   endfunction

   task automatic set_mod(input big_t m);
      big_t inv, t;
      gm  = m;
      inv = m & (pw(S) - 1);
      for (int i = 0; i < 6; i++) begin
         t   = (m * inv) & (pw(S) - 1);
         t   = (pw(S) + 2 - t) & (pw(S) - 1);
         inv = (inv * t) & (pw(S) - 1);
      end
      gk1 = (pw(S) - inv) & (pw(S) - 1);
      gc6 = pw(6*S) % m;
      gc5 = pw(5*S) % m;
      gtab[0] = '0;
      gtab[1] = pw(4*S) % m;
      gtab[2] = gtab[1];
      gtab[3] = pw(4*S+1) % m;
      gtab[4] = gc5;
      gtab[5] = (gc5 + gtab[1]) % m;
      gtab[6] = gtab[5];
      gtab[7] = (gc5 + gtab[3]) % m;
      mod_m   = m[N-1:0];
      mont_k  = gk1[S-1:0];
      fold6_k = gc6[N-1:0];
      fold5_k = gc5[N-1:0];
      for (int i = 1; i < 8; i++) corr_tab[(i-1)*N +: N] = gtab[i][N-1:0];
   endtask

   // one cycle: drive after negedge, sample before the next posedge
   task automatic step(input bit rnd, input bit hold_low);
      big_t x, e;
      @(negedge clk);
      #1;
      cyc++;
      if (!pend) begin
         if (stim_q.size() > 0 && (!rnd || $urandom_range(0, 3) != 0)) begin
            in_prod  = stim_q.pop_front();
            in_valid = 1'b1;
            pend     = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
      out_ready = hold_low ? 1'b0 : (rnd ? ($urandom_range(0, 3) != 0) : 1'b1);
      #1;
      if (in_valid && in_ready) begin
         exp_q.push_back(model(big_t'(in_prod)));
         x_q.push_back(big_t'(in_prod));
         acc_q.push_back(cyc);
         pend = 1'b0;
      end
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 output with nothing accepted", big_t'(out_res), '0);
         end else begin
            e = exp_q.pop_front();
            x = x_q.pop_front();
            last_lat = cyc - acc_q.pop_front();
            last_out = big_t'(out_res);
            chk(big_t'(out_res) == e, "R2/R3/R4/R5/R6 exact result", big_t'(out_res), e);
            chk(((big_t'(out_res) << S) % gm) == (x % gm),
                "R1 congruence", (big_t'(out_res) << S) % gm, x % gm);
         end
      end
   endtask

   task automatic drain(input bit rnd);
      while (stim_q.size() > 0 || pend || exp_q.size() > 0) step(rnd, 1'b0);
      @(negedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   function automatic big_t rnd_op();
      big_t v;
      v = {$urandom(), $urandom()};
      return v & (pw(N) - 1);
   endfunction

   function automatic big_t rnd_mod();
      return pw(N-1) | (rnd_op() & (pw(N-1) - 1)) | big_t'(1);
   endfunction

   task automatic load_batch(input int cnt);
      big_t a, b, p;
      a = pw(N) - 1;
      p = a * a;                         // forces fold carries (R2, R3)
      stim_q.push_back(p[8*S-1:0]);
      stim_q.push_back('0);
      for (int i = 0; i < cnt; i++) begin
         a = rnd_op();
         b = rnd_op();
         if (i % 5 == 0) a = gm - 1;
         p = a * b;
         stim_q.push_back(p[8*S-1:0]);
      end
   endtask

   initial begin
      big_t m0, a0, b0, p0, held;
      void'($urandom(32'h5eed_1234));
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      chk(out_valid == 1'b0, "R9 out_valid low in reset", big_t'(out_valid), '0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(in_ready == 1'b1, "R9 in_ready after reset", big_t'(in_ready), 1);
      chk(out_valid == 1'b0, "R9 out_valid after reset", big_t'(out_valid), '0);

      // counterexample-style modulus and operands just above 2^(N-1)
      m0 = pw(N-1) + 111;
      set_mod(m0);
      a0 = pw(N-1) + 110;
      b0 = pw(N-2) + 53;
      p0 = a0 * b0;
      stim_q.push_back(p0[8*S-1:0]);
      drain(1'b0);
      // R8 latency with out_ready held high
      chk(last_lat == 4, "R8 latency", big_t'(last_lat), 4);

      // R7: value between m and 2^N passes unchanged
      p0 = (m0 + 5) << S;
      stim_q.push_back(p0[8*S-1:0]);
      drain(1'b0);
      chk(last_out == m0 + 5, "R7 above-m result kept", last_out, m0 + 5);
      chk(last_out >= m0, "R7 result not below m", last_out, m0);

      // R8 hold while stalled
      stim_q.push_back(p0[8*S-1:0]);
      while (!out_valid) step(1'b0, 1'b1);
      held = big_t'(out_res);
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1);
         chk(out_valid && big_t'(out_res) == held, "R8 stalled output stable",
             big_t'(out_res), held);
      end
      drain(1'b0);

      load_batch(30);
      drain(1'b1);

      for (int k = 0; k < 4; k++) begin
         set_mod(rnd_mod());
         load_batch(30);
         drain(1'b1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule